// File: doc/BRIEF.md
# Bus-Start Restarted Watchdog Supervisor

This block supervises a host processor that proves it is alive by opening transactions on a two-wire serial bus. The clock line and data line of the bus are brought in through two-flop synchronisers. A bus start condition is a high-to-low transition of the data line while the clock line stays high. Every start reloads a down-counter with the full timeout of the selected period. The counter advances on a prescaled tick that fires once every `TICK_DIV` clocks. If the counter reaches its end before another start arrives, the block pulls an active-low reset output for a fixed number of ticks. While that pulse is being driven, bus activity is ignored. Once the pulse ends, the counter reloads and watching resumes.

A 2-bit selector picks one of three timeout lengths or switches supervision off. When supervision is off, the counter stays at zero and does not toggle. A change of the selector reloads the counter with the newly chosen period.

The controller has three states. `WS_IDLE` is the off state. `WS_RUN` counts toward a timeout. `WS_RST` drives the reset pulse. The transitions are:
- IDLE→RUN when the selector leaves off.
- RUN→IDLE when the selector becomes off.
- RUN→RST when the count runs out on a tick.
- RST→RUN or RST→IDLE when the pulse count runs out on a tick, chosen by the selector at that moment.

Synchronous reset places the block in RUN, or in IDLE if the selector is off, with the count loaded.

Top module: `bus_wdog_sup`

## Requirements
- R1: While `srst` is high, and on the first cycle after it falls, `rst_n_o` is high. The counter is loaded with the period of the current selector.
- R2: A start condition reloads the counter with the full selected period, so the reset output stays high while starts arrive more often than the timeout. A start is a falling synchronised data line while the synchronised clock line is high.
- R3: Selector code 00 selects `PERIOD0` ticks, 01 selects `PERIOD1` and 10 selects `PERIOD2`. After that many ticks with no start, `rst_n_o` goes low on a tick edge. One tick equals `TICK_DIV` clocks.
- R4: The low pulse on `rst_n_o` lasts exactly `RST_TICKS * TICK_DIV` clocks. Afterwards the counter holds the full period, so with no start the next pulse begins exactly `Pselected * TICK_DIV` clocks after the rise.
- R5: Start conditions that occur during the reset pulse neither lengthen nor shorten it.
- R6: Selector code 11 disables supervision: `rst_n_o` stays high and the counter rests at zero.
- R7: A change of the selector while counting reloads the counter with the period of the new code.
- R8: Data-line edges while the clock line is low, and rising data-line edges while the clock line is high, are not starts and do not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| srst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial bus clock line, asynchronous |
| sda_i | input | 1 | Serial bus data line, asynchronous |
| wd_sel_i | input | 2 | Timeout selector: 00, 01, 10 periods, 11 off |
| rst_n_o | output | 1 | Supervisor reset output, active low |

## Verification
The bench builds the block with `TICK_DIV=4`, periods of 12, 8 and 5 ticks, and a 3-tick pulse. A full timeout therefore takes at most 48 clocks. This makes exact pulse widths and the reload distance after a pulse measurable in clock counts, and lets every selector code, a selector change in mid-count and starts landing inside a pulse all be reached within a few thousand cycles. A behavioural model driven by the same pins predicts the reset output on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RUN  = 2'd1,
        WS_RST  = 2'd2
    } wd_state_t;

    localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (srst) stg[0] <= RST_VAL;
        else      stg[0] <= d_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (srst) stg[g] <= RST_VAL;
                else      stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wdg_start_det.sv
module wdg_start_det (
    input  logic clk,
    input  logic srst,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o
);
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (srst) sda_prev <= 1'b1;
        else      sda_prev <= sda_s;
    end

    // falling data line with the clock line high
    assign start_o = scl_s & sda_prev & ~sda_s;
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic srst,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pc_q;

    assign tick_o = (pc_q == LAST);

    always_ff @(posedge clk) begin
        if (srst)        pc_q <= '0;
        else if (tick_o) pc_q <= '0;
        else             pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/bus_wdog_sup.sv
module bus_wdog_sup #(
    parameter int TICK_DIV  = 50000,
    parameter int PERIOD0   = 1400,
    parameter int PERIOD1   = 600,
    parameter int PERIOD2   = 200,
    parameter int RST_TICKS = 250
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] wd_sel_i,
    output logic       rst_n_o
);
    import wdg_pkg::*;

    localparam int MAX01 = (PERIOD0 > PERIOD1) ? PERIOD0 : PERIOD1;
    localparam int MAX2R = (PERIOD2 > RST_TICKS) ? PERIOD2 : RST_TICKS;
    localparam int MAXP  = (MAX01 > MAX2R) ? MAX01 : MAX2R;
    localparam int CW    = $clog2(MAXP + 1);
    localparam logic [CW-1:0] RST_W = CW'(RST_TICKS);

    logic          scl_s, sda_s, start, tick;
    wd_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, per_sel;
    logic [1:0]    sel_q;
    logic          sel_off, sel_chg;

    wdg_sync2 #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .srst (srst),
        .d_i  ({scl_i, sda_i}),
        .q_o  ({scl_s, sda_s})
    );

    wdg_start_det u_det (
        .clk     (clk),
        .srst    (srst),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start)
    );

    wdg_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .srst   (srst),
        .tick_o (tick)
    );

    // period chosen by the selector
    always_comb begin
        unique case (wd_sel_i)
            2'b00:   per_sel = CW'(PERIOD0);
            2'b01:   per_sel = CW'(PERIOD1);
            2'b10:   per_sel = CW'(PERIOD2);
            default: per_sel = '0;
        endcase
    end

    assign sel_off = (wd_sel_i == SEL_OFF);
    assign sel_chg = (wd_sel_i != sel_q);

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_IDLE: begin
                if (!sel_off) begin
                    state_d = WS_RUN;
                    cnt_d   = per_sel;
                end else begin
                    cnt_d   = '0;
                end
            end
            WS_RUN: begin
                if (sel_off) begin
                    state_d = WS_IDLE;
                    cnt_d   = '0;
                end else if (sel_chg || start) begin
                    cnt_d   = per_sel;
                end else if (tick) begin
                    if (cnt_q <= CW'(1)) begin
                        state_d = WS_RST;
                        cnt_d   = RST_W;
                    end else begin
                        cnt_d   = cnt_q - 1'b1;
                    end
                end
            end
            WS_RST: begin
                if (tick) begin
                    if (cnt_q <= CW'(1)) begin
                        if (sel_off) begin
                            state_d = WS_IDLE;
                            cnt_d   = '0;
                        end else begin
                            state_d = WS_RUN;
                            cnt_d   = per_sel;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = WS_RUN;
                cnt_d   = per_sel;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= sel_off ? WS_IDLE : WS_RUN;
            cnt_q   <= per_sel;
            sel_q   <= wd_sel_i;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= wd_sel_i;
        end
    end

    // outputs
    always_comb begin
        rst_n_o = (state_q != WS_RST);
    end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
    parameter int CW = 4
) (
    input logic              clk,
    input logic              srst,
    input logic [1:0]        wd_sel_i,
    input logic              rst_n_o,
    input logic              tick,
    input logic              start,
    input wdg_pkg::wd_state_t state_q,
    input logic [CW-1:0]     cnt_q,
    input logic [CW-1:0]     per_sel,
    input logic [1:0]        sel_q
);
    import wdg_pkg::*;

    // R1
    reset_release_chk: assert property (@(posedge clk)
        srst |=> rst_n_o);

    // R3
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(rst_n_o) |-> $past(tick));

    // R4
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_n_o) |-> $past(tick));

    // R5
    pulse_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (state_q == WS_RST && !tick) |=> ($stable(cnt_q) && state_q == WS_RST));

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (srst)
        (wd_sel_i == SEL_OFF && rst_n_o) |=> rst_n_o);

    // R7
    sel_reload_chk: assert property (@(posedge clk) disable iff (srst)
        (state_q == WS_RUN && wd_sel_i != sel_q && wd_sel_i != SEL_OFF)
        |=> (cnt_q == $past(per_sel)));

    // R2
    start_reload_chk: assert property (@(posedge clk) disable iff (srst)
        (state_q == WS_RUN && start && wd_sel_i == sel_q && wd_sel_i != SEL_OFF)
        |=> (cnt_q == $past(per_sel)));
endmodule

bind bus_wdog_sup wdg_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .wd_sel_i (wd_sel_i),
    .rst_n_o  (rst_n_o),
    .tick     (tick),
    .start    (start),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .per_sel  (per_sel),
    .sel_q    (sel_q)
);

// File: tb/sim_bus_wdog_sup.sv
`timescale 1ns/1ps
module sim_bus_wdog_sup;
    localparam int DIV = 4;
    localparam int P0  = 12;
    localparam int P1  = 8;
    localparam int P2  = 5;
    localparam int RW  = 3;

    logic clk = 1'b0;
    logic srst, scl, sda, rst_n;
    logic [1:0] sel;

    always #2 clk = ~clk;

    bus_wdog_sup #(
        .TICK_DIV(DIV), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2), .RST_TICKS(RW)
    ) u0 (
        .clk(clk), .srst(srst), .scl_i(scl), .sda_i(sda),
        .wd_sel_i(sel), .rst_n_o(rst_n)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int per_of(input logic [1:0] s);
        case (s)
            2'b00:   return P0;
            2'b01:   return P1;
            2'b10:   return P2;
            default: return 0;
        endcase
    endfunction

    // behavioural reference: pipelines as integers, state as a small code
    int m_c1, m_c2, m_d1, m_d2, m_dp, m_pc, m_st, m_cnt;
    logic [1:0] m_sel;
    bit m_go = 0;

    always @(posedge clk) begin
        bit st_ev, tk;
        cyc++;
        if (srst) begin
            m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1; m_dp = 1; m_pc = 0;
            m_sel = sel;
            m_st  = (sel == 2'b11) ? 0 : 1;
            m_cnt = per_of(sel);
            m_go  = 1;
        end else if (m_go) begin
            st_ev = (m_c2 == 1) && (m_dp == 1) && (m_d2 == 0);
            tk    = (m_pc == DIV - 1);
            if (m_st == 0) begin
                if (sel != 2'b11) begin m_st = 1; m_cnt = per_of(sel); end
            end else if (m_st == 1) begin
                if (sel == 2'b11) begin m_st = 0; m_cnt = 0; end
                else if (sel != m_sel || st_ev) m_cnt = per_of(sel);
                else if (tk) begin
                    if (m_cnt <= 1) begin m_st = 2; m_cnt = RW; end
                    else m_cnt--;
                end
            end else begin
                if (tk) begin
                    if (m_cnt <= 1) begin
                        if (sel == 2'b11) begin m_st = 0; m_cnt = 0; end
                        else begin m_st = 1; m_cnt = per_of(sel); end
                    end else m_cnt--;
                end
            end
            m_dp = m_d2; m_d2 = m_d1; m_d1 = int'(sda);
            m_c2 = m_c1; m_c1 = int'(scl);
            m_pc = tk ? 0 : m_pc + 1;
            m_sel = sel;
        end
    end

    // run-length monitor and per-clock comparison
    int cur_low = 0, last_low = 0, cur_high = 0, last_high = 0;
    bit low_seen = 0;
    always @(negedge clk) begin
        if (m_go) check(rst_n == (m_st != 2), "R3 model", int'(rst_n), int'(m_st != 2));
        if (!srst) begin
            if (!rst_n) begin
                low_seen = 1;
                cur_low++;
                if (cur_high > 0) begin last_high = cur_high; cur_high = 0; end
            end else begin
                cur_high++;
                if (cur_low > 0) begin last_low = cur_low; cur_low = 0; end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc >= 60000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick();
        sda = 1'b0; wait_cyc(3);
        scl = 1'b0; wait_cyc(2);
        sda = 1'b1; wait_cyc(2);
        scl = 1'b1; wait_cyc(2);
    endtask

    task automatic non_start_edges();
        scl = 1'b0; wait_cyc(2);
        sda = 1'b0; wait_cyc(3);
        sda = 1'b1; wait_cyc(3);
        sda = 1'b0; wait_cyc(2);
        scl = 1'b1; wait_cyc(3);
        sda = 1'b1; wait_cyc(3);
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        while (rst_n && n < 500) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rise();
        int k = 0;
        while (!rst_n && k < 500) begin @(negedge clk); k++; end
    endtask

    initial begin
        int n;
        logic [1:0] sels [3] = '{2'b00, 2'b01, 2'b10};
        srst = 1'b1; scl = 1'b1; sda = 1'b1; sel = 2'b00;
        wait_cyc(4);
        check(rst_n == 1'b1, "R1 during reset", int'(rst_n), 1);
        srst = 1'b0;
        wait_cyc(1);
        check(rst_n == 1'b1, "R1 after reset", int'(rst_n), 1);

        // R2: regular starts keep the output high
        low_seen = 0;
        for (int i = 0; i < 10; i++) begin kick(); wait_cyc(20); end
        check(low_seen == 0, "R2 kept alive", int'(low_seen), 0);

        // R3 / R4 for every period code
        for (int i = 0; i < 3; i++) begin
            int p;
            sel = sels[i];
            p = per_of(sel);
            kick();
            wait_fall(n);
            check(n >= (p - 1) * DIV - 9 && n <= p * DIV, "R3 timeout", n, p * DIV);
            wait_rise();
            wait_cyc(1);
            check(last_low == RW * DIV, "R4 pulse width", last_low, RW * DIV);
            wait_fall(n);
            wait_cyc(1);
            check(last_high == p * DIV, "R4 reload after pulse", last_high, p * DIV);
            wait_rise();
        end

        // R5: starts inside the pulse are ignored
        sel = 2'b00;
        kick();
        wait_fall(n);
        kick();
        wait_rise();
        wait_cyc(1);
        check(last_low == RW * DIV, "R5 pulse unchanged", last_low, RW * DIV);
        wait_fall(n);
        wait_cyc(1);
        check(last_high == P0 * DIV, "R5 no reload from pulse starts", last_high, P0 * DIV);
        wait_rise();

        // R6: off keeps output high
        sel = 2'b11;
        low_seen = 0;
        wait_cyc(300);
        check(low_seen == 0, "R6 off", int'(low_seen), 0);
        sel = 2'b00;
        wait_cyc(5);
        check(rst_n == 1'b1, "R6 leaving off", int'(rst_n), 1);

        // R7: selector change reloads with the new period
        kick();
        wait_cyc(20);
        sel = 2'b10;
        wait_fall(n);
        check(n <= P2 * DIV + 1, "R7 new period", n, P2 * DIV);
        wait_rise();

        // R8: non-start edges do not reload
        sel = 2'b01;
        kick();
        low_seen = 0;
        for (int i = 0; i < 3; i++) non_start_edges();
        check(low_seen == 1, "R8 no reload", int'(low_seen), 1);
        wait_rise();

        wait_cyc(10);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule